// File: doc/BRIEF.md
# Buffered Multi-Mode Serial Transmitter

This block is the transmit half of a serial port. Software-style writes place one byte in a holding register. On a bit tick, when the shifter is free or has just sent the last bit of its frame, that byte moves into a shift register. The holding register is then free at once for the next byte. A frame is built around the byte according to a two-bit framing mode and a few option inputs. Bits leave on a single serial pin, one per bit tick, least significant data bit first.

Four framings are supported. The first is asynchronous with an optional even or odd parity bit. The second is asynchronous with an address/data marker bit. The third is clock-synchronous, with start and stop bits optional. The last is plain asynchronous. The holding-register-empty flag rises when the byte is taken into the shifter, not when the frame ends. A maskable interrupt follows that flag, so a driver can refill the holding register while the previous byte is still going out. In the synchronous mode this gives gap-free streams.

Top module: `mode_serial_tx`

## Requirements
- R1: After reset, `hold_empty` is 1 and `txd` is 1 (idle level). `tx_irq` is 0 when `irq_en` is 0 and 1 when `irq_en` is 1.
- R2: A cycle with `wr_en` high stores `wr_data` and makes `hold_empty` 0 at the next clock edge. This holds even when the shifter takes the previous byte in that same cycle; the taken byte is then the previous one.
- R3: `tx_irq` is 1 exactly while `hold_empty` is 1 and `irq_en` is 1.
- R4: On a `bit_tick`, if the holding register is full and the shifter is idle or has finished its last bit, the byte is taken. The first frame bit appears on `txd` and `hold_empty` becomes 1 at that same clock edge.
- R5: Data bits go out least significant bit first. Each occupies exactly one bit-tick period.
- R6: Mode 0 (`mode`=0) sends start 0, 8 data bits, stop 1. With `par_en`=1 a parity bit is inserted after D7. With `par_odd`=0 that bit is the XOR of the data bits; with `par_odd`=1 it is the inverse.
- R7: Mode 1 sends start 0, 8 data bits, the `adr_flag` value sampled when the byte is taken, then stop 1.
- R8: Mode 3 sends start 0, 8 data bits, stop 1, and never a parity bit, whatever `par_en` is.
- R9: Mode 2 with `sync_framed`=0 sends only the 8 data bits. If the holding register was refilled before the last bit ended, D0 of the next byte follows D7 on the very next tick.
- R10: Mode 2 with `sync_framed`=1 sends start 0, 8 data bits and stop 1, with no parity.
- R11: When a frame ends with the holding register empty, `txd` returns to 1 and stays there. A later write starts a new frame on the next tick.
- R12: `txd` changes only at clock edges where `bit_tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| mode | input | 2 | Framing mode: 0 async+parity option, 1 async+address bit, 2 synchronous, 3 plain async |
| par_en | input | 1 | Parity insert enable (mode 0 only) |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| adr_flag | input | 1 | Address/data marker value for mode 1 |
| sync_framed | input | 1 | Adds start/stop bits in mode 2 |
| irq_en | input | 1 | Transmit interrupt enable |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| hold_empty | output | 1 | Holding register empty flag |
| tx_irq | output | 1 | Transmit interrupt request |
| txd | output | 1 | Serial data out, idles at 1 |

## Verification
Several rules are checked by assertions on every cycle. They cover the interrupt gating and the flag clearing on writes and setting on takes. They also cover takes happening only on ticks, the idle line sitting high and the line holding still between ticks. The exact bit order and content of each framing cannot be seen by a per-cycle rule, so the bench's scenarios must show them. The same goes for the parity polarity, the gap-free joining of synchronous bytes and the write-versus-take collision. The bench compares every serial bit against frames it builds from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    FM_ASYNC_PAR   = 2'd0,
    FM_ASYNC_ADR   = 2'd1,
    FM_SYNC        = 2'd2,
    FM_ASYNC_PLAIN = 2'd3
  } frame_mode_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_empty <= 1'b1;
    end else if (wr_en) begin
      hold_data  <= wr_data;
      hold_empty <= 1'b0;
    end else if (take) begin
      hold_empty <= 1'b1;
    end
  end

  // R2: a write always leaves the register full
  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);
  // R4: a take without a competing write frees the register
  p_take_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> hold_empty);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  frame_mode_e       fmode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              adr_flag,
  input  logic              sync_framed,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);

  function automatic logic has_extra(frame_mode_e m, logic pen);
    return (m == FM_ASYNC_ADR) || (m == FM_ASYNC_PAR && pen);
  endfunction

  function automatic logic bare_sync(frame_mode_e m, logic framed);
    return (m == FM_SYNC) && !framed;
  endfunction

  function automatic logic extra_value(frame_mode_e m, logic odd, logic adr,
                                       logic [DATA_W-1:0] d);
    if (m == FM_ASYNC_ADR) return adr;
    return (^d) ^ odd;
  endfunction

  function automatic logic [FW-1:0] frame_bits(frame_mode_e m, logic pen, logic odd,
                                               logic adr, logic framed,
                                               logic [DATA_W-1:0] d);
    logic [FW-1:0] b;
    b = '1;
    if (bare_sync(m, framed)) begin
      b[DATA_W-1:0] = d;
    end else begin
      b[0] = 1'b0;
      b[DATA_W:1] = d;
      if (has_extra(m, pen)) b[DATA_W+1] = extra_value(m, odd, adr, d);
    end
    return b;
  endfunction

  function automatic logic [CW-1:0] frame_len(frame_mode_e m, logic pen, logic framed);
    if (bare_sync(m, framed)) return CW'(DATA_W);
    if (has_extra(m, pen)) return CW'(DATA_W + 3);
    return CW'(DATA_W + 2);
  endfunction

  logic [FW-1:0] shreg;
  logic [CW-1:0] remain;
  logic [FW-1:0] next_frame;
  logic [CW-1:0] next_len;
  logic          last_bit;

  always_comb begin
    next_frame = frame_bits(fmode, par_en, par_odd, adr_flag, sync_framed, hold_data);
    next_len   = frame_len(fmode, par_en, sync_framed);
  end

  assign last_bit = busy && (remain == '0);
  assign take     = bit_tick && hold_full && (!busy || last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      txd    <= 1'b1;
      shreg  <= '1;
      remain <= '0;
    end else if (bit_tick) begin
      if (take) begin
        txd    <= next_frame[0];
        shreg  <= {1'b1, next_frame[FW-1:1]};
        remain <= next_len - CW'(1);
        busy   <= 1'b1;
      end else if (busy && !last_bit) begin
        txd    <= shreg[0];
        shreg  <= {1'b1, shreg[FW-1:1]};
        remain <= remain - CW'(1);
      end else begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end
    end
  end

  // R11: idle shifter drives the line high
  p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R12: line only moves on tick edges
  p_txd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));
  // R4: bytes are taken only on a tick
  p_take_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> bit_tick);
  // R5: bit counter stays within the longest frame
  p_remain_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CW'(FW - 1));
endmodule

// File: rtl/mode_serial_tx.sv
module mode_serial_tx
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              adr_flag,
  input  logic              sync_framed,
  input  logic              irq_en,
  input  logic              bit_tick,
  output logic              hold_empty,
  output logic              tx_irq,
  output logic              txd
);
  logic              take_evt;
  logic              shift_busy;
  logic [DATA_W-1:0] hold_data;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take_evt), .hold_data(hold_data), .hold_empty(hold_empty)
  );

  sertx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fmode(frame_mode_e'(mode)),
    .par_en(par_en), .par_odd(par_odd), .adr_flag(adr_flag),
    .sync_framed(sync_framed), .hold_full(!hold_empty), .hold_data(hold_data),
    .take(take_evt), .busy(shift_busy), .txd(txd)
  );

  assign tx_irq = hold_empty & irq_en;

  // R3: no request unless the register is empty and enabled
  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (hold_empty && irq_en));
  // R4: taking a byte starts a frame
  p_take_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> shift_busy);
endmodule

// File: tb/test_mode_serial_tx.sv
module test_mode_serial_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {mode[1:0], par_en, par_odd, adr, framed, data[7:0]}
  localparam logic [13:0] VECS [NVEC] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h37},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5C},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hF0},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3E},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 8'h96},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, par_en = 0, par_odd = 0;
  logic adr_flag = 0, sync_framed = 0, irq_en = 0, bit_tick = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] mode = 0;
  logic hold_empty, tx_irq, txd;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_serial_tx i_mode_serial_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
    .par_en(par_en), .par_odd(par_odd), .adr_flag(adr_flag),
    .sync_framed(sync_framed), .irq_en(irq_en), .bit_tick(bit_tick),
    .hold_empty(hold_empty), .tx_irq(tx_irq), .txd(txd)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1;
    @(negedge clk) bit_tick = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_byte(logic [7:0] d);
    @(negedge clk) begin wr_en = 1; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  // expected frame, built as an ordered bit list
  function automatic int exp_len(logic [13:0] v);
    if (v[13:12] == 2'd2) return v[8] ? 10 : 8;
    if (v[13:12] == 2'd1) return 11;
    if (v[13:12] == 2'd0 && v[11]) return 11;
    return 10;
  endfunction

  function automatic logic exp_bit(logic [13:0] v, int k);
    int ones = 0;
    int off;
    for (int i = 0; i < 8; i++) ones += v[i];
    if (v[13:12] == 2'd2 && !v[8]) return v[k];
    if (k == 0) return 1'b0;
    off = k - 1;
    if (off < 8) return v[off];
    if (off == 8 && exp_len(v) == 11) begin
      if (v[13:12] == 2'd1) return v[9];
      return (ones % 2 == 1) ? !v[10] : v[10];
    end
    return 1'b1;
  endfunction

  function automatic string tag_of(logic [13:0] v);
    case (v[13:12])
      2'd0: return "R6";
      2'd1: return "R7";
      2'd3: return "R8";
      default: return v[8] ? "R10" : "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 empty", hold_empty, 1);
    check("R1 txd", txd, 1);
    check("R1 irq off", tx_irq, 0);
    irq_en = 1; #1;
    check("R1 irq on", tx_irq, 1);

    foreach (VECS[i]) begin
      logic [13:0] v = VECS[i];
      mode = v[13:12]; par_en = v[11]; par_odd = v[10];
      adr_flag = v[9]; sync_framed = v[8];
      write_byte(v[7:0]);
      check("R2 full", hold_empty, 0);
      check("R3 irq low", tx_irq, 0);
      repeat (3) @(negedge clk);
      check("R11 idle before tick", txd, 1);
      for (int k = 0; k < exp_len(v); k++) begin
        tick();
        if (k == 0) begin
          check("R4 empty", hold_empty, 1);
          check("R3 irq", tx_irq, 1);
          adr_flag = !v[9]; // R7: later change must not matter
        end
        check({tag_of(v), " R5 bit"}, txd, exp_bit(v, k));
        repeat (3) @(negedge clk);
        check("R12 stable", txd, exp_bit(v, k));
      end
      tick();
      check("R11 idle", txd, 1);
    end

    // R9 back-to-back with R2 write/take collision
    mode = 2'd2; sync_framed = 0;
    write_byte(8'hB1);
    tick();
    check("R9 A0", txd, 1'b1);
    write_byte(8'h4E);
    for (int k = 1; k < 8; k++) begin
      tick();
      check("R9 A bit", txd, (8'hB1 >> k) & 1);
    end
    @(negedge clk) begin bit_tick = 1; wr_en = 1; wr_data = 8'h6D; end
    @(negedge clk) begin bit_tick = 0; wr_en = 0; end
    check("R9 B0 adjacent", txd, 1'b0);
    check("R2 collision full", hold_empty, 0);
    for (int k = 1; k < 8; k++) begin
      tick();
      check("R9 B bit", txd, (8'h4E >> k) & 1);
    end
    tick();
    check("R2 C0 follows", txd, 1'b1);
    check("R4 empty after C", hold_empty, 1);
    for (int k = 1; k < 8; k++) begin
      tick();
      check("R9 C bit", txd, (8'h6D >> k) & 1);
    end
    tick();
    check("R11 idle end", txd, 1);
    irq_en = 0; #1;
    check("R3 masked", tx_irq, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule